// File: doc/BRIEF.md
# Interrupt Recognition and Priority Arbiter

This block sits beside a processor's sequencer and picks, at every instruction boundary, the single interrupt source that is serviced next. It gathers the per-instruction exception strobes, the single-step trap, a software-interrupt request with its operand, a non-maskable pin and a maskable request pin. While the instruction-end strobe is high it raises a grant pulse and drives the winning 8-bit type number on its output.

The non-maskable pin is filtered and held. A high level must be seen on a minimum number of consecutive clock edges before it counts as an event. The event is then held until it is granted, and each new event needs a fresh rising edge. The maskable pin is not stored: it is looked at only in the boundary cycle and only while the interrupt-enable flag is set. That one source takes its type from the bus, so the arbiter flags that an external acknowledge is needed and does not supply a type for it.

Top module: `irq_arbiter`

## Requirements
- R1: After reset no non-maskable event is pending, so a boundary cycle with no request raised gives no grant, type 0 and no acknowledge flag.
- R2: `grant` is high only in a cycle where `insn_end` is high and at least one source is requesting. When `grant` is low, `grant_type` is 0 and `ext_ack` is low.
- R3: The internal exceptions rank divide error (type 0) above single step (type 1), single step above breakpoint (type 3), and breakpoint above overflow (type 4).
- R4: The single-step trap requests service only when `tf_flag` is 1.
- R5: An overflow-trap request (`exc_into`) counts only when `of_flag` is 1. A breakpoint request (`exc_brk`) always counts.
- R6: A non-maskable event is recorded once `nmi_pin` has been high on 3 consecutive rising clock edges (parameter `NMI_MIN_HIGH`), and shorter pulses are dropped. The event waits for a boundary and is granted as type 2.
- R7: The held non-maskable event is cleared by its own grant. A pin kept high does not record a second event. A new rising edge that meets R6 records the event again, even while an earlier event is being serviced.
- R8: Between groups the order of service is: all internal exceptions, then the non-maskable event, then the software interrupt, then the maskable request.
- R9: A granted software interrupt drives `grant_type` equal to its operand `swi_type`, and `ext_ack` stays low.
- R10: The maskable request wins only if `intr_pin` and `if_flag` are both high in the boundary cycle. It is not stored. When it wins, `ext_ack` is 1 and `grant_type` is 0, because the type comes from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_end | input | 1 | High in the last clock of each instruction |
| exc_div | input | 1 | Divide-error exception from the current instruction |
| exc_brk | input | 1 | Breakpoint instruction executed |
| exc_into | input | 1 | Overflow-trap instruction executed |
| of_flag | input | 1 | Overflow flag value |
| tf_flag | input | 1 | Trap (single-step) flag value |
| if_flag | input | 1 | Interrupt-enable flag value |
| nmi_pin | input | 1 | Non-maskable request pin |
| intr_pin | input | 1 | Maskable level request pin |
| swi_req | input | 1 | Software-interrupt instruction executed |
| swi_type | input | TYPE_W | Type operand of the software interrupt |
| grant | output | 1 | One-cycle service grant at the boundary |
| grant_type | output | TYPE_W | Type number of the granted source |
| ext_ack | output | 1 | Granted source needs external acknowledge cycles |

## Verification
The assertions check on every cycle that at most one source wins, that a grant appears only at a boundary, that the acknowledge flag appears only for an enabled maskable request, that a divide error always wins, and that the held non-maskable event sets only behind a high pin and clears after its grant. The bench scenarios cover the parts that depend on history. These are the pulse-width filter that drops two-cycle pulses, the rule that a held-high pin records only one event, re-recording after a new edge, and the full order of service for mixed requests. The bench checks these against a model built from the requirements, using a seeded random stream together with directed cases.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   // source slots, listed from highest to lowest service rank
   localparam int unsigned SLOT_DIV  = 0;
   localparam int unsigned SLOT_STEP = 1;
   localparam int unsigned SLOT_BRK  = 2;
   localparam int unsigned SLOT_OVF  = 3;
   localparam int unsigned SLOT_NMI  = 4;
   localparam int unsigned SLOT_SWI  = 5;
   localparam int unsigned SLOT_MASK = 6;
   localparam int unsigned NUM_SLOTS = 7;

   // fixed type numbers
   localparam int unsigned TYP_DIV  = 0;
   localparam int unsigned TYP_STEP = 1;
   localparam int unsigned TYP_NMI  = 2;
   localparam int unsigned TYP_BRK  = 3;
   localparam int unsigned TYP_OVF  = 4;
endpackage

// File: rtl/nmi_capture.sv
module nmi_capture #(
   parameter int unsigned MIN_HIGH    = 3,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic clr,
   output logic pend
);
   localparam int unsigned CW = $clog2(MIN_HIGH + 1);

   generate
      if (MIN_HIGH < 1) begin : g_bad_min
         $error("nmi_capture: MIN_HIGH must be at least 1");
      end
   endgenerate

   logic pin_s;

   generate
      if (SYNC_STAGES == 0) begin : g_raw
         assign pin_s = pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], pin} ;
         end
         assign pin_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   logic [CW-1:0] hi_cnt;
   logic          accept;

   assign accept = pin_s && (hi_cnt == CW'(MIN_HIGH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
      end else if (!pin_s) begin
         hi_cnt <= '0;
      end else if (hi_cnt != CW'(MIN_HIGH)) begin
         hi_cnt <= hi_cnt + 1'b1;
      end
   end

   // a new accepted edge wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend <= 1'b0;
      else if (accept) pend <= 1'b1;
      else if (clr)    pend <= 1'b0;
   end

   // R6: the held event can only appear behind a high pin
   a_r6_set_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(pin_s));

   // R7: a grant of the held event removes it unless a new edge arrives
   a_r7_clear_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !accept) |=> !pend);
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] win
);
   generate
      if (N < 2) begin : g_bad_n
         $error("irq_prio_select: N must be at least 2");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_chain
         if (i == 0) begin : g_top
            assign win[i] = req[i];
         end else begin : g_rest
            assign win[i] = req[i] & ~(|req[i-1:0]);
         end
      end
   endgenerate

   // R8: exactly one winner whenever anything requests
   a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win) && ((|req) == (|win)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned TYPE_W          = 8,
   parameter int unsigned NMI_MIN_HIGH    = 3,
   parameter int unsigned NMI_SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_end,
   input  logic              exc_div,
   input  logic              exc_brk,
   input  logic              exc_into,
   input  logic              of_flag,
   input  logic              tf_flag,
   input  logic              if_flag,
   input  logic              nmi_pin,
   input  logic              intr_pin,
   input  logic              swi_req,
   input  logic [TYPE_W-1:0] swi_type,
   output logic              grant,
   output logic [TYPE_W-1:0] grant_type,
   output logic              ext_ack
);
   import irq_arb_pkg::*;

   generate
      if (TYPE_W < 3) begin : g_bad_w
         $error("irq_arbiter: TYPE_W must hold the fixed types");
      end
   endgenerate

   logic                 nmi_pend;
   logic [NUM_SLOTS-1:0] raw_req;
   logic [NUM_SLOTS-1:0] req;
   logic [NUM_SLOTS-1:0] win;

   always_comb begin
      raw_req            = '0;
      raw_req[SLOT_DIV]  = exc_div;
      raw_req[SLOT_STEP] = tf_flag;
      raw_req[SLOT_BRK]  = exc_brk;
      raw_req[SLOT_OVF]  = exc_into & of_flag;
      raw_req[SLOT_NMI]  = nmi_pend;
      raw_req[SLOT_SWI]  = swi_req;
      raw_req[SLOT_MASK] = intr_pin & if_flag;
   end

   assign req = raw_req & {NUM_SLOTS{insn_end}};

   nmi_capture #(
      .MIN_HIGH    (NMI_MIN_HIGH),
      .SYNC_STAGES (NMI_SYNC_STAGES)
   ) u_nmi (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (nmi_pin),
      .clr   (win[SLOT_NMI]),
      .pend  (nmi_pend)
   );

   irq_prio_select #(
      .N (NUM_SLOTS)
   ) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .win   (win)
   );

   assign grant   = |win;
   assign ext_ack = win[SLOT_MASK];

   always_comb begin
      grant_type = ({TYPE_W{win[SLOT_DIV]}}  & TYPE_W'(TYP_DIV))
                 | ({TYPE_W{win[SLOT_STEP]}} & TYPE_W'(TYP_STEP))
                 | ({TYPE_W{win[SLOT_BRK]}}  & TYPE_W'(TYP_BRK))
                 | ({TYPE_W{win[SLOT_OVF]}}  & TYPE_W'(TYP_OVF))
                 | ({TYPE_W{win[SLOT_NMI]}}  & TYPE_W'(TYP_NMI))
                 | ({TYPE_W{win[SLOT_SWI]}}  & swi_type);
   end

   // R2: grants only at an instruction boundary
   a_r2_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> insn_end);

   // R10: the acknowledge flag only for an enabled maskable request
   a_r10_ack_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ack |-> (grant && if_flag && intr_pin && grant_type == '0));

   // R3: a divide error always wins at a boundary
   a_r3_div_first: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_end && exc_div) |-> (grant && grant_type == '0 && !ext_ack));

   // R8: the held non-maskable event beats software and maskable sources
   a_r8_nmi_over_swi: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_end && nmi_pend && !exc_div && !tf_flag && !exc_brk && !(exc_into && of_flag))
      |-> (grant_type == TYPE_W'(TYP_NMI) && !ext_ack));
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       insn_end, exc_div, exc_brk, exc_into, of_flag, tf_flag, if_flag;
   logic       nmi_pin, intr_pin, swi_req;
   logic [7:0] swi_type;
   logic       grant, ext_ack;
   logic [7:0] grant_type;

   int tests = 0;
   int fails = 0;
   int m_cnt = 0;
   bit m_pend = 1'b0;

   always #10 clk = ~clk;

   irq_arbiter u_irq_arbiter (
      .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .exc_div(exc_div),
      .exc_brk(exc_brk), .exc_into(exc_into), .of_flag(of_flag),
      .tf_flag(tf_flag), .if_flag(if_flag), .nmi_pin(nmi_pin),
      .intr_pin(intr_pin), .swi_req(swi_req), .swi_type(swi_type),
      .grant(grant), .grant_type(grant_type), .ext_ack(ext_ack)
   );

   task automatic idle();
      insn_end = 0; exc_div = 0; exc_brk = 0; exc_into = 0; of_flag = 0;
      tf_flag = 0; if_flag = 0; intr_pin = 0; swi_req = 0; swi_type = 8'h00;
   endtask

   // check outputs against the requirement model, then advance the model
   task automatic go(string tag);
      bit       eg, ea, enmi;
      bit [7:0] et;
      int       old;
      #2;
      eg = 1; ea = 0; enmi = 0; et = 8'h00;
      if (!insn_end)                 begin eg = 0; end
      else if (exc_div)              et = 8'd0;
      else if (tf_flag)              et = 8'd1;
      else if (exc_brk)              et = 8'd3;
      else if (exc_into && of_flag)  et = 8'd4;
      else if (m_pend)               begin et = 8'd2; enmi = 1; end
      else if (swi_req)              et = swi_type;
      else if (intr_pin && if_flag)  ea = 1;
      else                           eg = 0;
      tests++;
      if (grant !== eg || grant_type !== et || ext_ack !== ea) begin
         fails++;
         $display("FAIL %s: grant/type/ack actual %b/%0d/%b expected %b/%0d/%b",
                  tag, grant, grant_type, ext_ack, eg, et, ea);
      end
      old = m_cnt;
      if (!nmi_pin) m_cnt = 0;
      else if (m_cnt != 3) m_cnt++;
      if (nmi_pin && old == 2) m_pend = 1;
      else if (enmi)           m_pend = 0;
   endtask

   task automatic nmi_pulse(int len);
      for (int k = 0; k < len; k++) begin
         @(negedge clk); idle(); nmi_pin = 1; go("R6");
      end
      @(negedge clk); idle(); nmi_pin = 0; go("R6");
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h1c0de;
      void'($urandom(seed));
      idle(); nmi_pin = 0; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: nothing pending after reset
      @(negedge clk); idle(); insn_end = 1; go("R1");

      // R3: internal ranking and types
      @(negedge clk); idle(); insn_end = 1; exc_div = 1; go("R3");
      @(negedge clk); idle(); insn_end = 1; exc_div = 1; tf_flag = 1; exc_brk = 1; go("R3");
      @(negedge clk); idle(); insn_end = 1; tf_flag = 1; exc_brk = 1; go("R3");
      @(negedge clk); idle(); insn_end = 1; exc_brk = 1; exc_into = 1; of_flag = 1; go("R3");
      // R4: single step gated by the trap flag
      @(negedge clk); idle(); insn_end = 1; tf_flag = 1; go("R4");
      @(negedge clk); idle(); insn_end = 1; tf_flag = 0; exc_brk = 1; go("R4");
      // R5: overflow trap gated by the overflow flag, breakpoint ungated
      @(negedge clk); idle(); insn_end = 1; exc_into = 1; of_flag = 0; go("R5");
      @(negedge clk); idle(); insn_end = 1; exc_into = 1; of_flag = 1; go("R5");
      @(negedge clk); idle(); insn_end = 1; exc_brk = 1; of_flag = 0; go("R5");

      // R6: a two-cycle pulse is dropped, a three-cycle pulse is kept
      nmi_pulse(2);
      @(negedge clk); idle(); insn_end = 1; go("R6");
      nmi_pulse(3);
      @(negedge clk); idle(); go("R6");
      @(negedge clk); idle(); insn_end = 1; go("R6");
      // R7: cleared by its grant
      @(negedge clk); idle(); insn_end = 1; go("R7");
      // R7: held-high pin records one event only
      for (int k = 0; k < 6; k++) begin @(negedge clk); idle(); nmi_pin = 1; go("R7"); end
      @(negedge clk); idle(); nmi_pin = 1; insn_end = 1; go("R7");
      @(negedge clk); idle(); nmi_pin = 1; go("R7");
      @(negedge clk); idle(); nmi_pin = 1; insn_end = 1; go("R7");
      // R7: re-recorded after a new edge
      @(negedge clk); idle(); nmi_pin = 0; go("R7");
      nmi_pulse(4);
      // R8: non-maskable over software and maskable, internal over non-maskable
      @(negedge clk); idle(); insn_end = 1; exc_brk = 1; swi_req = 1; go("R8");
      @(negedge clk); idle(); insn_end = 1; swi_req = 1; swi_type = 8'h21;
      intr_pin = 1; if_flag = 1; go("R8");
      // R9: software type passes through
      @(negedge clk); idle(); insn_end = 1; swi_req = 1; swi_type = 8'h5A; go("R9");
      @(negedge clk); idle(); insn_end = 1; swi_req = 1; swi_type = 8'hFF;
      intr_pin = 1; if_flag = 1; go("R9");
      // R10: maskable gating and no storage
      @(negedge clk); idle(); insn_end = 1; intr_pin = 1; if_flag = 0; go("R10");
      @(negedge clk); idle(); insn_end = 1; intr_pin = 1; if_flag = 1; go("R10");
      @(negedge clk); idle(); intr_pin = 1; if_flag = 1; go("R10");
      @(negedge clk); idle(); insn_end = 1; if_flag = 1; go("R10");
      // R2: no grant away from a boundary
      @(negedge clk); idle(); exc_div = 1; tf_flag = 1; swi_req = 1; intr_pin = 1;
      if_flag = 1; go("R2");

      // R8: seeded random mix
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         insn_end = ($urandom % 3) == 0;
         exc_div  = ($urandom % 8) == 0;
         tf_flag  = ($urandom % 6) == 0;
         exc_brk  = ($urandom % 8) == 0;
         exc_into = ($urandom % 5) == 0;
         of_flag  = $urandom % 2;
         if_flag  = $urandom % 2;
         intr_pin = $urandom % 2;
         swi_req  = ($urandom % 5) == 0;
         swi_type = 8'($urandom);
         if (($urandom % 4) == 0) nmi_pin = ~nmi_pin;
         go("R8");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule